// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches recent virtual-page-to-physical-frame translations for all processes at once. Each of its sixteen entries records a virtual page number, a physical frame number and the identifier of the owning process. A lookup presents a 32-bit virtual address and a process identifier. Bits 31:12 of the address are the page number and bits 11:0 are the byte offset. If a valid entry matches both the page and the process, the physical address (frame joined with offset) is returned one cycle later.

On a miss the block stops taking requests and asks an external page-table walker for the frame. It then writes the returned translation into a free entry or, when none is free, into a victim entry. The victim is chosen by a pseudo-random sequence or by least-recent use, and the choice between the two is made at reset. The stalled request then completes with the new frame. Software-visible invalidation is available for the whole buffer or for the entries of a single process.

Top module: `ptag_tlb`

## Requirements
- R1: The response address carries the frame number in bits 31:12 and the request's offset (vaddr bits 11:0) unchanged in bits 11:0.
- R2: A request accepted while req_ready_o is high hits when a valid entry holds both its page number (vaddr bits 31:12) and its process identifier. In the next cycle rsp_valid_o and rsp_hit_o are 1 and the address uses that entry's frame.
- R3: An entry with the same page number but a different process identifier does not hit. Any number of entries may hold the same frame number.
- R4: The cycle after a missing request is accepted, walk_req_o is 1 and walk_vpn_o/walk_pid_o show its page and process. req_ready_o stays 0 until the cycle after walk_ack_i.
- R5: When walk_ack_i is 1 while walk_req_o is 1, the translation (walk_frame_i) is installed. In the next cycle rsp_valid_o is 1, rsp_hit_o is 0, walk_req_o is 0 and req_ready_o is 1. Later lookups of that page and process hit.
- R6: An install uses the lowest-indexed invalid entry whenever any entry is invalid.
- R7: With least-recent-use replacement and no invalid entry, the victim is the entry whose last hit or install lies furthest back.
- R8: With random replacement and no invalid entry, the victim index is bits 3:0 of a 16-bit register. The register is loaded with 0xACE1 in reset and, on every other clock, shifts left by one with bit 0 taking bit15 XOR bit13 XOR bit12 XOR bit10.
- R9: policy_lru_i (1 = least recent use, 0 = random) is sampled only while rst_ni is low. Later changes have no effect.
- R10: A cycle with flush_all_i high invalidates every entry, so lookups accepted from the next cycle miss.
- R11: A cycle with flush_pid_en_i high invalidates only the entries tagged with flush_pid_i. Other entries keep hitting.
- R12: After reset req_ready_o is 1, rsp_valid_o and walk_req_o are 0, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| policy_lru_i | input | 1 | Replacement select, sampled in reset: 1 least recent use, 0 random |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Lookup accepted when high |
| req_vaddr_i | input | 32 | Virtual address |
| req_pid_i | input | 8 | Requesting process identifier |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | 1 if served from the buffer, 0 if after a walk |
| rsp_paddr_o | output | 32 | Physical address |
| walk_req_o | output | 1 | Refill request to the walker |
| walk_vpn_o | output | 20 | Page number to walk |
| walk_pid_o | output | 8 | Process of the walk |
| walk_ack_i | input | 1 | Walker returns the frame |
| walk_frame_i | input | 20 | Frame from the walker |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_pid_en_i | input | 1 | Invalidate entries of one process |
| flush_pid_i | input | 8 | Process to invalidate |

## Verification
A hit response is due exactly one rising edge after the request is accepted. A refill request is also raised one edge after a missing request is accepted. The refill response is due one edge after the walker's acknowledge. The bench drives every input on a falling edge and reads the outputs on the following falling edge, so each check lands in the one cycle where the result must show. The bench keeps its own record of entries, last-use timestamps and the stated shift-register sequence. From that record it predicts hit or miss, the returned frame and every victim over sweeps across all sixteen entries in both replacement modes.

// File: rtl/ptag_tlb_pkg.sv
package ptag_tlb_pkg;

  typedef enum logic { ST_IDLE, ST_WALK } tlb_state_e;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Fibonacci step for x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/ptag_tlb_match.sv
module ptag_tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ENTRIES-1:0]              valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_i,
  input  logic [ENTRIES-1:0][PID_W-1:0]   pid_i,
  input  logic [VPN_W-1:0]                look_vpn_i,
  input  logic [PID_W-1:0]                look_pid_i,
  output logic                            hit_any_o,
  output logic [IDX_W-1:0]                hit_idx_o
);

  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (vpn_i[g] == look_vpn_i) && (pid_i[g] == look_pid_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_any_o = |hit_vec;

  // R3: installs only follow misses, so a page/process pair never lives twice
  assert_unique_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

endmodule

// File: rtl/ptag_tlb_victim.sv
module ptag_tlb_victim
  import ptag_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               policy_lru_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               touch_en_i,
  input  logic [IDX_W-1:0]   touch_idx_i,
  output logic [IDX_W-1:0]   victim_idx_o
);

  logic                          pol_lru_q;
  logic [LFSR_W-1:0]             lfsr_q;
  logic [ENTRIES-1:0][IDX_W-1:0] age_q;
  logic [ENTRIES-1:0]            oldest_vec;
  logic                          free_any;
  logic [IDX_W-1:0]              free_idx;
  logic [IDX_W-1:0]              oldest_idx;

  // R9: policy captured only during reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) pol_lru_q <= policy_lru_i;
  end

  // R8: free-running pseudo-random source
  always_ff @(posedge clk_i) begin
    if (!rst_ni) lfsr_q <= LFSR_SEED;
    else         lfsr_q <= lfsr_next(lfsr_q);
  end

  // R7: ages form a permutation; touched entry becomes youngest
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx_i)           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
  end

  always_comb begin
    free_any   = 1'b0;
    free_idx   = '0;
    oldest_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (oldest_vec[i]) oldest_idx = IDX_W'(i);
    end
  end

  assign victim_idx_o = free_any  ? free_idx :
                        pol_lru_q ? oldest_idx : lfsr_q[IDX_W-1:0];

  assert_lru_single_oldest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest_vec) == 1);

  assert_free_before_evict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_any |-> !valid_i[victim_idx_o]);

  assert_policy_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(pol_lru_q));

endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
  import ptag_tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int PID_W   = 8,
  parameter int ENTRIES = 16,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               policy_lru_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [PID_W-1:0]   req_pid_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [PA_W-1:0]    rsp_paddr_o,
  output logic               walk_req_o,
  output logic [VPN_W-1:0]   walk_vpn_o,
  output logic [PID_W-1:0]   walk_pid_o,
  input  logic               walk_ack_i,
  input  logic [FRAME_W-1:0] walk_frame_i,
  input  logic               flush_all_i,
  input  logic               flush_pid_en_i,
  input  logic [PID_W-1:0]   flush_pid_i
);

  function automatic logic [PA_W-1:0] join_paddr(input logic [FRAME_W-1:0] f,
                                                 input logic [OFF_W-1:0]   o);
    return {f, o};
  endfunction

  logic [ENTRIES-1:0]              valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [ENTRIES-1:0][PID_W-1:0]   pid_q;
  logic [ENTRIES-1:0][FRAME_W-1:0] frame_q;
  tlb_state_e                      state_q;
  logic [VPN_W-1:0]                lk_vpn_q;
  logic [PID_W-1:0]                lk_pid_q;
  logic [OFF_W-1:0]                lk_off_q;
  logic                            rsp_valid_q, rsp_hit_q;
  logic [PA_W-1:0]                 rsp_paddr_q;

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx, victim_idx, touch_idx;
  logic             acc, acc_hit, acc_miss, fill_fire;

  assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign req_off = req_vaddr_i[OFF_W-1:0];

  ptag_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) match_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_q),
    .vpn_i      (vpn_q),
    .pid_i      (pid_q),
    .look_vpn_i (req_vpn),
    .look_pid_i (req_pid_i),
    .hit_any_o  (hit_any),
    .hit_idx_o  (hit_idx)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign acc         = req_valid_i && req_ready_o;
  assign acc_hit     = acc && hit_any;
  assign acc_miss    = acc && !hit_any;
  assign fill_fire   = (state_q == ST_WALK) && walk_ack_i;
  assign touch_idx   = fill_fire ? victim_idx : hit_idx;

  ptag_tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .policy_lru_i (policy_lru_i),
    .valid_i      (valid_q),
    .touch_en_i   (acc_hit || fill_fire),
    .touch_idx_i  (touch_idx),
    .victim_idx_o (victim_idx)
  );

  // Install first, then invalidations win over the fresh entry
  always_comb begin
    valid_d = valid_q;
    if (fill_fire) valid_d[victim_idx] = 1'b1;
    if (flush_all_i) valid_d = '0;
    if (flush_pid_en_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (((fill_fire && victim_idx == IDX_W'(i)) ? lk_pid_q : pid_q[i]) == flush_pid_i)
          valid_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      valid_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_paddr_q <= '0;
      lk_vpn_q    <= '0;
      lk_pid_q    <= '0;
      lk_off_q    <= '0;
    end else begin
      valid_q     <= valid_d;
      rsp_valid_q <= acc_hit || fill_fire;
      if (acc) begin
        lk_vpn_q <= req_vpn;
        lk_pid_q <= req_pid_i;
        lk_off_q <= req_off;
      end
      if (acc_hit) begin
        rsp_hit_q   <= 1'b1;
        rsp_paddr_q <= join_paddr(frame_q[hit_idx], req_off);
      end
      if (acc_miss) state_q <= ST_WALK;
      if (fill_fire) begin
        rsp_hit_q   <= 1'b0;
        rsp_paddr_q <= join_paddr(walk_frame_i, lk_off_q);
        state_q     <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_fire) begin
      vpn_q[victim_idx]   <= lk_vpn_q;
      pid_q[victim_idx]   <= lk_pid_q;
      frame_q[victim_idx] <= walk_frame_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_paddr_o = rsp_paddr_q;
  assign walk_req_o  = (state_q == ST_WALK);
  assign walk_vpn_o  = lk_vpn_q;
  assign walk_pid_o  = lk_pid_q;

  assert_hit_next_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit |=> rsp_valid_o && rsp_hit_o);

  assert_offset_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit |=> rsp_paddr_o[OFF_W-1:0] == $past(req_off));

  assert_miss_walks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_miss |=> walk_req_o && !req_ready_o && walk_vpn_o == $past(req_vpn)
                 && walk_pid_o == $past(req_pid_i));

  assert_fill_completes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_fire |=> rsp_valid_o && !rsp_hit_o && req_ready_o && !walk_req_o
                  && rsp_paddr_o[PA_W-1:OFF_W] == $past(walk_frame_i));

  assert_flush_all_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> valid_q == '0);

endmodule

// File: tb/ptag_tlb_tb_top.sv
`timescale 1ns/1ps
module ptag_tlb_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        policy = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_pid = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_paddr;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic [7:0]  walk_pid;
  logic        walk_ack = 1'b0;
  logic [19:0] walk_frame = '0;
  logic        flush_all = 1'b0;
  logic        flush_pid_en = 1'b0;
  logic [7:0]  flush_pid = '0;

  always #4 clk = ~clk;

  ptag_tlb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .policy_lru_i(policy),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_pid_i(req_pid), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .rsp_paddr_o(rsp_paddr), .walk_req_o(walk_req), .walk_vpn_o(walk_vpn),
    .walk_pid_o(walk_pid), .walk_ack_i(walk_ack), .walk_frame_i(walk_frame),
    .flush_all_i(flush_all), .flush_pid_en_i(flush_pid_en), .flush_pid_i(flush_pid)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // Reference record of the buffer
  logic [19:0] m_vpn[N];
  logic [7:0]  m_pid[N];
  logic [19:0] m_frame[N];
  bit          m_valid[N];
  longint      m_stamp[N];
  longint      stamp_ctr;
  bit          m_lru;
  logic [15:0] m_lfsr;

  // R8: sequence restated from the requirement
  always @(posedge clk) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  end

  function automatic int m_find(input logic [19:0] vpn, input logic [7:0] pid);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int b;
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    if (m_lru) begin
      b = 0;
      for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[b]) b = i;
      return b;
    end
    return int'(m_lfsr[3:0]);
  endfunction

  task automatic do_reset(input bit lru);
    rst_n  = 1'b0;
    policy = lru;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_lru = lru;
    stamp_ctr = 0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0;
      m_stamp[i] = 0;
    end
    @(negedge clk);
    chk(req_ready && !rsp_valid && !walk_req, "R12", "idle after reset",
        {req_ready, rsp_valid, walk_req}, 3'b100);
    policy = ~lru;  // R9: must be ignored from here on
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [7:0] pid, input logic [19:0] fr, input string rq);
    int k;
    int v;
    @(negedge clk);
    chk(req_ready, "R4", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_pid   = pid;
    k = m_find(vpn, pid);
    @(negedge clk);
    req_valid = 1'b0;
    if (k >= 0) begin
      chk(rsp_valid && rsp_hit && !walk_req, rq, "hit response",
          {rsp_valid, rsp_hit, walk_req}, 3'b110);
      chk(rsp_paddr == {m_frame[k], off}, "R1", "hit address", rsp_paddr, {m_frame[k], off});
      stamp_ctr++;
      m_stamp[k] = stamp_ctr;
    end else begin
      chk(walk_req && !rsp_valid, rq, "miss raises walk", {walk_req, rsp_valid}, 2'b10);
      chk(walk_vpn == vpn && walk_pid == pid, "R4", "walk page/process",
          {walk_vpn, walk_pid}, {vpn, pid});
      repeat (2) begin
        @(negedge clk);
        chk(!req_ready && walk_req, "R4", "stalled during walk", {req_ready, walk_req}, 2'b01);
      end
      walk_ack   = 1'b1;
      walk_frame = fr;
      v = m_victim();
      @(negedge clk);
      walk_ack = 1'b0;
      chk(rsp_valid && !rsp_hit && !walk_req && req_ready, "R5", "refill response",
          {rsp_valid, rsp_hit, walk_req, req_ready}, 4'b1001);
      chk(rsp_paddr == {fr, off}, "R1", "refill address", rsp_paddr, {fr, off});
      m_valid[v] = 1'b1;
      m_vpn[v]   = vpn;
      m_pid[v]   = pid;
      m_frame[v] = fr;
      stamp_ctr++;
      m_stamp[v] = stamp_ctr;
    end
  endtask

  task automatic do_flush_pid(input logic [7:0] p);
    @(negedge clk);
    flush_pid_en = 1'b1;
    flush_pid    = p;
    @(negedge clk);
    flush_pid_en = 1'b0;
    for (int i = 0; i < N; i++) if (m_pid[i] == p) m_valid[i] = 1'b0;
  endtask

  task automatic do_flush_all();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog: run never completed act=%0h exp=%0h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // Least-recent-use configuration
    do_reset(1'b1);
    for (int i = 0; i < N; i++)                        // R6 fill, R3 shared frames
      lookup(20'h100 + 20'(i), 12'(i * 13), 8'(i % 3), 20'(i % 5), "R6");
    for (int j = 0; j < N; j++)                        // R2 and R9 under toggled policy
      lookup(20'h100 + 20'((j * 5) % N), 12'(j * 77), 8'(((j * 5) % N) % 3), 20'hFFFFF, "R9");
    lookup(20'h100, 12'h234, 8'd7, 20'h0AAAA, "R3");   // same page, foreign process
    for (int j = 0; j < 6; j++)
      lookup(20'h200 + 20'(j), 12'(j), 8'd0, 20'h00200 + 20'(j), "R7");
    for (int i = 0; i < N; i++)
      lookup(20'h100 + 20'(i), 12'hFFF, 8'(i % 3), 20'h00300 + 20'(i), "R7");
    do_flush_pid(8'd1);
    for (int i = 0; i < N; i++)
      lookup(20'h100 + 20'(i), 12'h001, 8'(i % 3), 20'h00400 + 20'(i), "R11");
    do_flush_all();
    for (int i = 0; i < 4; i++)
      lookup(20'h100 + 20'(i), 12'h800, 8'(i % 3), 20'h00500 + 20'(i), "R10");

    // Random configuration
    do_reset(1'b0);
    for (int i = 0; i < N; i++)
      lookup(20'h400 + 20'(i), 12'(i), 8'd2, 20'h01000 + 20'(i), "R6");
    for (int j = 0; j < 24; j++)
      lookup(20'h500 + 20'(j), 12'(j * 3), 8'd3, 20'h02000 + 20'(j), "R8");
    for (int i = 0; i < N; i++)
      lookup(20'h400 + 20'(i), 12'h0F0, 8'd2, 20'h03000 + 20'(i), "R8");
    for (int j = 0; j < 24; j++)
      lookup(20'h500 + 20'(j), 12'h00F, 8'd3, 20'h04000 + 20'(j), "R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule